// File: doc/BRIEF.md
# Conversion Sequencer with Power Management

This block sequences a sampling converter through three phases: idle, acquisition (sample switch closed) and conversion (busy). A single conversion-control input, CNV, drives it. When CNV falls while the block is idle, the sample switch closes. When CNV later rises, the switch opens and a conversion of fixed length starts. The block counts that length on the system clock. When the conversion ends, the block gives a one-cycle done pulse and returns to idle.

A 2-bit power-mode input chooses what idle looks like after each conversion: fully powered, sleep, or power-down. The mode is captured only on the cycle that ends a conversion, so a new setting first shows in the idle that follows the next conversion. Leaving a low-power idle state needs a longer acquisition. While that requirement is still unmet, the power-state output reports a settling code. A sticky fault flag records two kinds of violation: a conversion started before the required acquisition time, and a CNV high pulse that is too narrow. Every time limit is given in nanoseconds and turned into clock cycles from the clock frequency parameter.

Top module: `cnv_seq_pm`

## Requirements
- R1: After reset the block is idle with the power state fully powered (code 00), the sample switch open, busy and done low and the fault flag clear.
- R2: With no synchronizer stages, the sample switch output rises on the clock edge that first samples CNV low while idle. On the edge that first samples CNV high during acquisition, the switch output falls and busy rises. The two outputs are never high together.
- R3: Busy stays high for exactly the conversion length in cycles. On the edge where busy falls, done is high for exactly one cycle, and the block is idle again.
- R4: The power state shown in idle after a conversion is decoded from the mode sampled on the conversion-ending edge: 00 gives power-down (code 10), 01 gives fully powered (code 00), and 10 or 11 give sleep (code 01), because the upper mode bit overrides the lower one.
- R5: A mode change made while idle does not alter the idle power state until a conversion completes.
- R6: The acquisition time needed depends on the idle state just left: the full-power, sleep or power-down figure. While sampling, the power state is 11 (settling) until the switch has been closed for one cycle less than that figure, and 00 from then on. During conversion the power state is 00.
- R7: A conversion started after fewer sampled-low cycles than required sets the fault flag. Exactly the required count does not set it. Once set, the flag stays set until reset.
- R8: CNV falling during a conversion after fewer sampled-high cycles than the minimum pulse width sets the fault flag. Exactly the minimum does not set it.
- R9: CNV edges during a conversion do not restart or lengthen it. A CNV that is already low when the conversion ends does not start an acquisition.
- R10: A rising CNV edge while idle has no effect: the sample switch stays open, busy stays low and the idle power state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Conversion control: falling edge starts sampling, rising edge starts conversion |
| pm_mode_i | input | 2 | Requested power mode, captured at the end of each conversion |
| pwr_state_o | output | 2 | 00 full power, 01 sleep, 10 power-down, 11 settling while sampling |
| sample_on_o | output | 1 | Sample switch closed (acquisition) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse at the end of a conversion |
| acq_fault_o | output | 1 | Sticky timing fault flag |

## Verification
The bench builds the block at 100 MHz with no synchronizer stages. It uses a 200 ns conversion, acquisition figures of 50, 120 and 300 ns, and a 40 ns minimum pulse, which gives 20, 5, 12, 30 and 4 cycles. With these values the power-down wake limit can be reached in tens of cycles instead of thousands, so each acquisition and pulse limit can be hit exactly and also missed by one cycle. Without synchronizer stages every CNV edge maps to a known clock edge, so the settling window and the busy length can be checked cycle by cycle.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

  typedef enum logic [1:0] {
    PL_FULL   = 2'b00,
    PL_SLEEP  = 2'b01,
    PL_DOWN   = 2'b10,
    PL_SETTLE = 2'b11
  } pwr_lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ACQ  = 2'b01,
    ST_CONV = 2'b10
  } seq_st_e;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // The upper mode bit selects sleep, whatever the lower bit holds.
  function automatic pwr_lvl_e mode_to_lvl(input logic [1:0] m);
    if (m[1]) return PL_SLEEP;
    if (m[0]) return PL_FULL;
    return PL_DOWN;
  endfunction

  function automatic int acq_need(input pwr_lvl_e lvl, input int full_c,
                                  input int sleep_c, input int down_c);
    case (lvl)
      PL_SLEEP: return sleep_c;
      PL_DOWN:  return down_c;
      default:  return full_c;
    endcase
  endfunction

  // A counter value n, seen on the edge that ends a window, means
  // the window lasted n+1 cycles.
  function automatic logic window_short(input int cnt, input int need);
    return (cnt + 1) < need;
  endfunction

endpackage

// File: rtl/cnv_edge_det.sv
module cnv_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic s_w;
  logic prev_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= din;
          for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign s_w = chain_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign s_w = din;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s_w;
  end

  assign rise = s_w & ~prev_q;
  assign fall = ~s_w & prev_q;

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (en && cnt != TOP)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cnv_pwr_ctrl.sv
module cnv_pwr_ctrl
  import cnv_seq_pkg::*;
#(
  parameter int FULL_C  = 40,
  parameter int SLEEP_C = 170,
  parameter int DOWN_C  = 15000,
  parameter int W       = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wake,
  input  logic         conv_end,
  input  logic [1:0]   pm_mode,
  output pwr_lvl_e     idle_lvl,
  output logic [W-1:0] need
);

  pwr_lvl_e       idle_lvl_q;
  logic [W-1:0]   need_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_lvl_q <= PL_FULL;
      need_q     <= W'(FULL_C);
    end else begin
      if (conv_end) idle_lvl_q <= mode_to_lvl(pm_mode);
      if (wake)     need_q     <= W'(acq_need(idle_lvl_q, FULL_C, SLEEP_C, DOWN_C));
    end
  end

  assign idle_lvl = idle_lvl_q;
  assign need     = need_q;

endmodule

// File: rtl/cnv_seq_pm.sv
module cnv_seq_pm
  import cnv_seq_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int CONV_NS      = 3600,
  parameter int ACQ_FULL_NS  = 400,
  parameter int ACQ_SLEEP_NS = 1700,
  parameter int ACQ_PD_NS    = 150000,
  parameter int PULSE_MIN_NS = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnv_i,
  input  logic [1:0] pm_mode_i,
  output logic [1:0] pwr_state_o,
  output logic       sample_on_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       acq_fault_o
);

  localparam int CONV_CYC = ns_to_cyc(CONV_NS, CLK_MHZ);
  localparam int FULL_C   = ns_to_cyc(ACQ_FULL_NS, CLK_MHZ);
  localparam int SLEEP_C  = ns_to_cyc(ACQ_SLEEP_NS, CLK_MHZ);
  localparam int DOWN_C   = ns_to_cyc(ACQ_PD_NS, CLK_MHZ);
  localparam int PULSE_C  = ns_to_cyc(PULSE_MIN_NS, CLK_MHZ);
  localparam int MAX_C    = max_of3(max_of3(CONV_CYC, FULL_C, SLEEP_C), DOWN_C, PULSE_C);
  localparam int CW       = $clog2(MAX_C + 2);

  // Named events, visible to the checker.
  logic          evt_rise_w, evt_fall_w;
  logic          wake_w, start_w, conv_end_w;
  logic          acq_short_w, pulse_short_w;
  logic [CW-1:0] acq_cnt_w, conv_cnt_w, hi_cnt_w, need_w;
  pwr_lvl_e      idle_lvl_w, pwr_lvl_w;
  int            conv_len_w;

  seq_st_e st_q;
  logic    done_q, fault_q, pulse_open_q;

  cnv_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cnv_i),
    .rise (evt_rise_w),
    .fall (evt_fall_w)
  );

  assign wake_w     = (st_q == ST_IDLE) && evt_fall_w;
  assign start_w    = (st_q == ST_ACQ)  && evt_rise_w;
  assign conv_end_w = (st_q == ST_CONV) && (conv_cnt_w == CW'(CONV_CYC - 1));

  seq_timer #(.W(CW)) u_acq_tmr (
    .clk(clk), .rst_n(rst_n), .clr(wake_w), .en(st_q == ST_ACQ), .cnt(acq_cnt_w)
  );

  seq_timer #(.W(CW)) u_conv_tmr (
    .clk(clk), .rst_n(rst_n), .clr(start_w), .en(st_q == ST_CONV), .cnt(conv_cnt_w)
  );

  seq_timer #(.W(CW)) u_hi_tmr (
    .clk(clk), .rst_n(rst_n), .clr(start_w),
    .en((st_q == ST_CONV) && pulse_open_q), .cnt(hi_cnt_w)
  );

  cnv_pwr_ctrl #(
    .FULL_C(FULL_C), .SLEEP_C(SLEEP_C), .DOWN_C(DOWN_C), .W(CW)
  ) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wake    (wake_w),
    .conv_end(conv_end_w),
    .pm_mode (pm_mode_i),
    .idle_lvl(idle_lvl_w),
    .need    (need_w)
  );

  assign acq_short_w   = start_w && window_short(int'(acq_cnt_w), int'(need_w));
  assign pulse_short_w = (st_q == ST_CONV) && pulse_open_q && evt_fall_w &&
                         window_short(int'(hi_cnt_w), PULSE_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (wake_w)     st_q <= ST_ACQ;
        ST_ACQ:  if (start_w)    st_q <= ST_CONV;
        ST_CONV: if (conv_end_w) st_q <= ST_IDLE;
        default:                 st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      pulse_open_q <= 1'b0;
    end else begin
      done_q  <= conv_end_w;
      fault_q <= fault_q | acq_short_w | pulse_short_w;
      if (start_w)                       pulse_open_q <= 1'b1;
      else if (evt_fall_w || conv_end_w) pulse_open_q <= 1'b0;
    end
  end

  always_comb begin
    case (st_q)
      ST_ACQ:  pwr_lvl_w = window_short(int'(acq_cnt_w), int'(need_w)) ? PL_SETTLE : PL_FULL;
      ST_CONV: pwr_lvl_w = PL_FULL;
      default: pwr_lvl_w = idle_lvl_w;
    endcase
  end

  assign conv_len_w  = CONV_CYC;
  assign pwr_state_o = pwr_lvl_w;
  assign sample_on_o = (st_q == ST_ACQ);
  assign busy_o      = (st_q == ST_CONV);
  assign done_o      = done_q;
  assign acq_fault_o = fault_q;

endmodule

// File: rtl/cnv_seq_pm_chk.sv
module cnv_seq_pm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_state_o,
  input logic       sample_on_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       acq_fault_o,
  input int         conv_len_i
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  AST_SAMPLE_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_on_o && busy_o)); // R2
  AST_BUSY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(sample_on_o)); // R2
  AST_CONV_FULL_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> pwr_state_o == 2'b00); // R6
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> run_len == conv_len_i); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    acq_fault_o |=> acq_fault_o); // R7
  AST_IDLE_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_on_o && !busy_o && $past(!sample_on_o && !busy_o)) |-> $stable(pwr_state_o)); // R5
  AST_SETTLE_ONLY_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state_o == 2'b11 |-> sample_on_o); // R6

endmodule

bind cnv_seq_pm cnv_seq_pm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_state_o(pwr_state_o),
  .sample_on_o(sample_on_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .acq_fault_o(acq_fault_o),
  .conv_len_i (conv_len_w)
);

// File: tb/cnv_seq_pm_tb.sv
module cnv_seq_pm_tb;

  localparam int CONV_C  = 20;
  localparam int FULL_C  = 5;
  localparam int SLEEP_C = 12;
  localparam int DOWN_C  = 30;
  localparam int PULSE_C = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnv = 1'b1;
  logic [1:0] mode = 2'b01;
  logic [1:0] pwr_state_o;
  logic       sample_on_o, busy_o, done_o, acq_fault_o;

  always #5 clk = ~clk;

  cnv_seq_pm #(
    .CLK_MHZ(100), .CONV_NS(200), .ACQ_FULL_NS(50), .ACQ_SLEEP_NS(120),
    .ACQ_PD_NS(300), .PULSE_MIN_NS(40), .SYNC_STAGES(0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .pm_mode_i(mode),
    .pwr_state_o(pwr_state_o), .sample_on_o(sample_on_o), .busy_o(busy_o),
    .done_o(done_o), .acq_fault_o(acq_fault_o)
  );

  int n_run  = 0;
  int n_fail = 0;

  typedef struct {
    logic [1:0] lvl;
    logic       fault;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [1:0] model_lvl   = 2'b00;
  logic       model_fault = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Mode to idle level: 00 -> 10, 01 -> 00, 1x -> 01.
  function automatic logic [1:0] lvl_of(input logic [1:0] m);
    case (m)
      2'b00:   return 2'b10;
      2'b01:   return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int need_of(input logic [1:0] l);
    if (l == 2'b01) return SLEEP_C;
    if (l == 2'b10) return DOWN_C;
    return FULL_C;
  endfunction

  // Monitor: pop one expected item for every done pulse.
  always @(posedge clk) begin
    #1;
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 done without a started conversion", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pwr_state_o == e.lvl, "R4 idle level after done", pwr_state_o, e.lvl);
        chk(acq_fault_o == e.fault, e.tag, acq_fault_o, e.fault);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cnv   = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_lvl   = 2'b00;
    model_fault = 1'b0;
    @(posedge clk); #1;
    chk(pwr_state_o == 2'b00 && !sample_on_o && !busy_o && !done_o && !acq_fault_o,
        "R1 reset state", {pwr_state_o, sample_on_o, busy_o, done_o, acq_fault_o}, 0);
  endtask

  // Driver: one acquisition plus conversion, with its expected result queued.
  task automatic run_conv(input int acq_n, input int hi_n, input bit drop,
                          input bit rerise, input string ftag);
    int         need, busy_n, k, bad_p, exp_bad;
    bit         acq_ok, settle_ok;
    logic [1:0] nl, exp_p;
    exp_t       e;
    need = need_of(model_lvl);
    if (acq_n < need) model_fault = 1'b1;
    if (drop && hi_n < PULSE_C) model_fault = 1'b1;
    nl = lvl_of(mode);
    e.lvl = nl; e.fault = model_fault; e.tag = ftag;
    exp_q.push_back(e);

    @(negedge clk) cnv = 1'b0;
    acq_ok = 1'b1; settle_ok = 1'b1; bad_p = 0; exp_bad = 0;
    for (int j = 0; j < acq_n; j++) begin
      @(posedge clk); #1;
      if (!sample_on_o || busy_o) acq_ok = 1'b0;
      exp_p = (j + 1 < need) ? 2'b11 : 2'b00;
      if (pwr_state_o != exp_p) begin
        settle_ok = 1'b0; bad_p = pwr_state_o; exp_bad = exp_p;
      end
    end
    chk(acq_ok, "R2 switch closed through acquisition", acq_ok, 1);
    chk(settle_ok, "R6 settling indication", bad_p, exp_bad);

    @(negedge clk) cnv = 1'b1;
    busy_n = 0;
    k = 0;
    do begin
      @(posedge clk); #1;
      k++;
      if (k == 1)
        chk(busy_o && !sample_on_o, "R2 rising CNV starts conversion", busy_o, 1);
      if (busy_o) busy_n++;
      if (drop && k == hi_n) begin @(negedge clk); cnv = 1'b0; end
      if (rerise && k == hi_n + 3) begin @(negedge clk); cnv = 1'b1; end
    end while (!done_o && k < 1000);
    chk(busy_n == CONV_C, "R3 R9 busy length", busy_n, CONV_C);
    model_lvl = nl;

    @(posedge clk); #1;
    chk(!done_o && !busy_o && !sample_on_o, "R3 done is a single cycle", done_o, 0);
    if (cnv == 1'b0) begin
      repeat (3) @(posedge clk);
      #1;
      chk(!sample_on_o && !busy_o, "R9 low CNV at end starts nothing", sample_on_o, 0);
      @(negedge clk) cnv = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk(!sample_on_o && !busy_o && pwr_state_o == model_lvl,
          "R10 rising CNV in idle ignored", pwr_state_o, model_lvl);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    mode = 2'b01;
    run_conv(6, 25, 1'b0, 1'b0, "R7 long acquisition, no fault");
    run_conv(5, 25, 1'b0, 1'b0, "R7 exact minimum, no fault");
    mode = 2'b10;
    run_conv(5, 25, 1'b0, 1'b0, "R4 sleep requested");

    @(negedge clk) mode = 2'b00;
    repeat (4) @(posedge clk);
    #1;
    chk(pwr_state_o == 2'b01, "R5 idle level held after mode change", pwr_state_o, 1);

    run_conv(12, 6, 1'b1, 1'b0, "R6 sleep wake at minimum");
    mode = 2'b11;
    run_conv(30, 25, 1'b0, 1'b0, "R6 power-down wake at minimum");
    mode = 2'b01;
    run_conv(11, 25, 1'b0, 1'b0, "R7 short acquisition after sleep");
    run_conv(6, 25, 1'b0, 1'b0, "R7 fault stays set");

    do_reset();
    run_conv(6, PULSE_C, 1'b1, 1'b1, "R8 minimum pulse, no fault");
    run_conv(6, PULSE_C - 1, 1'b1, 1'b0, "R8 narrow pulse sets fault");

    chk(exp_q.size() == 0, "R3 every conversion completed", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule